// File: doc/BRIEF.md
# Window Watchdog with Reset Generation

This block supervises the service pulses of a microcontroller. It counts watchdog cycles on a single-cycle tick input and checks each trigger against a window. After power-up, and again after every watchdog reset, the block opens a long window. During that window the controller may synchronize with its first trigger. From then on each service period is a closed window of 12 ticks followed by an open window of 20 ticks. A trigger that lands in the open window starts the next closed window at once. A trigger that comes while the window is closed, or an open window that runs out with no trigger, pulls the active-low reset output low for 4 ticks. It also sets a sticky diagnosis flag and drives a one-cycle pulse that clears the configuration register.

Two qualifiers change the supervision. A sleep request suspends the watchdog and forces the low-side outputs off. The request is the auto-disable bit of the configuration register together with the low-current input. On wake-up, the first closed window is merged into open time, so the controller gets one open window of 32 ticks. The flash-programming qualifier switches supervision off completely.

Top module: `wdog_window`

## Requirements
- R1: After `rst_n` is released, `wdog_rst_n` is high, `diag_flag` and `cfg_clr` are low, and a long open window of `LONG_CYC` ticks (default 256) begins. If that window's last tick passes with no trigger, `wdog_rst_n` goes low.
- R2: A trigger edge in a long, open or wake window starts a closed window of `CLOSED_CYC` ticks (default 12). A trigger edge while the closed window is active, including on its last tick, pulls `wdog_rst_n` low in the next cycle.
- R3: When a closed window completes, an open window of `OPEN_CYC` ticks (default 20) follows. A trigger anywhere in it is a valid service. If the 20th open tick passes with no trigger, `wdog_rst_n` goes low.
- R4: `wdog_rst_n` stays low for exactly `RST_CYC` ticks (default 4). It then returns high and a new long open window begins.
- R5: `diag_flag` goes high when a watchdog reset starts. It stays high until a `diag_clr` strobe. If a new reset starts in the same cycle as the strobe, the flag stays set.
- R6: `cfg_clr` is high for exactly one clock cycle, the first cycle in which `wdog_rst_n` is low.
- R7: While `auto_dis_en` and `low_cur` are both high (outside a running reset), supervision is suspended. `ls_off` is high and no reset is produced, however many ticks pass.
- R8: When `low_cur` falls during suspension, one open window of `CLOSED_CYC+OPEN_CYC` ticks (32) begins. A trigger up to its 31st tick is valid. After the 32nd tick with no trigger, a reset follows.
- R9: While `flash_mode` is high the watchdog never drives `wdog_rst_n` low, and triggers have no effect. When `flash_mode` falls, a fresh long open window begins.
- R10: Only a rising edge of `trig` counts as a service. Holding `trig` high counts once.
- R11: Window counters advance only on clock cycles with `tick` high. Any number of clock cycles without a tick causes no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low power-on/undervoltage reset |
| tick | input | 1 | Single-cycle watchdog timebase pulse |
| trig | input | 1 | Service signal from the microcontroller (rising edge counts) |
| auto_dis_en | input | 1 | Configuration bit permitting suspension at low current |
| low_cur | input | 1 | Low supply current qualifier |
| flash_mode | input | 1 | Flash-programming qualifier, disables the watchdog |
| diag_clr | input | 1 | Strobe clearing the diagnosis flag |
| wdog_rst_n | output | 1 | Active-low watchdog reset |
| diag_flag | output | 1 | Sticky flag: a watchdog reset occurred |
| cfg_clr | output | 1 | One-cycle pulse clearing the configuration register |
| ls_off | output | 1 | Forces low-side outputs off during suspension |

## Verification
Triggers are placed at the first and last ticks of the closed window, at several offsets inside the open window, and one tick after the open window has run out. These cases separate "too early", "valid" and "too late" at each edge. A trigger held high across a whole period shows whether the block sees levels or edges. Long stretches of clock with no ticks show whether timing follows the tick or the clock. Sleep followed by wake-up, with service at tick 31 and with silence through tick 32, shows the merged 32-tick window. Sleep with the enable bit low, and flash mode with triggers, separate real suspension from a block that merely ignores its qualifiers.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int CLOSED_CYC = 12,
  parameter int OPEN_CYC   = 20,
  parameter int RST_CYC    = 4,
  parameter int LONG_CYC   = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic trig,
  input  logic auto_dis_en,
  input  logic low_cur,
  input  logic flash_mode,
  input  logic diag_clr,
  output logic wdog_rst_n,
  output logic diag_flag,
  output logic cfg_clr,
  output logic ls_off
);

  localparam int WAKE_CYC = CLOSED_CYC + OPEN_CYC;
  localparam int MAX_A    = (LONG_CYC > WAKE_CYC) ? LONG_CYC : WAKE_CYC;
  localparam int MAX_CYC  = (MAX_A > RST_CYC) ? MAX_A : RST_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  localparam logic [CW-1:0] CL_LAST = CW'(CLOSED_CYC - 1);
  localparam logic [CW-1:0] OP_LAST = CW'(OPEN_CYC - 1);
  localparam logic [CW-1:0] RS_LAST = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] LG_LAST = CW'(LONG_CYC - 1);
  localparam logic [CW-1:0] WK_LAST = CW'(WAKE_CYC - 1);

  typedef enum logic [2:0] {
    S_LONG, S_CLOSED, S_OPEN, S_RESET, S_SLEEP, S_WAKE
  } wd_state_e;

  wd_state_e     state, state_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          trig_q;
  logic          trig_edge;
  logic          sleep_req;
  logic          fire;
  logic [CW-1:0] open_last;

  assign trig_edge = trig & ~trig_q;
  assign sleep_req = auto_dis_en & low_cur;

  always_comb begin
    case (state)
      S_OPEN:  open_last = OP_LAST;
      S_WAKE:  open_last = WK_LAST;
      default: open_last = LG_LAST;
    endcase
  end

  always_comb begin
    state_nxt = state;
    cnt_nxt   = cnt;
    fire      = 1'b0;
    if (flash_mode) begin
      state_nxt = S_LONG;
      cnt_nxt   = '0;
    end else begin
      case (state)
        S_RESET: begin
          if (tick) begin
            if (cnt == RS_LAST) begin
              state_nxt = S_LONG;
              cnt_nxt   = '0;
            end else begin
              cnt_nxt = cnt + 1'b1;
            end
          end
        end
        S_SLEEP: begin
          if (!sleep_req) begin
            state_nxt = S_WAKE;
            cnt_nxt   = '0;
          end
        end
        S_CLOSED: begin
          if (sleep_req) begin
            state_nxt = S_SLEEP;
            cnt_nxt   = '0;
          end else if (trig_edge) begin
            fire = 1'b1;
          end else if (tick) begin
            if (cnt == CL_LAST) begin
              state_nxt = S_OPEN;
              cnt_nxt   = '0;
            end else begin
              cnt_nxt = cnt + 1'b1;
            end
          end
        end
        default: begin
          if (sleep_req) begin
            state_nxt = S_SLEEP;
            cnt_nxt   = '0;
          end else if (trig_edge) begin
            state_nxt = S_CLOSED;
            cnt_nxt   = '0;
          end else if (tick) begin
            if (cnt == open_last) fire = 1'b1;
            else cnt_nxt = cnt + 1'b1;
          end
        end
      endcase
      if (fire) begin
        state_nxt = S_RESET;
        cnt_nxt   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_LONG;
      cnt       <= '0;
      trig_q    <= 1'b0;
      cfg_clr   <= 1'b0;
      diag_flag <= 1'b0;
    end else begin
      state   <= state_nxt;
      cnt     <= cnt_nxt;
      trig_q  <= trig;
      cfg_clr <= fire;
      if (fire) diag_flag <= 1'b1;
      else if (diag_clr) diag_flag <= 1'b0;
    end
  end

  assign wdog_rst_n = (state != S_RESET);
  assign ls_off     = (state == S_SLEEP);

endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic trig,
  input logic flash_mode,
  input logic wdog_rst_n,
  input logic diag_flag,
  input logic cfg_clr,
  input logic ls_off
);

  a_r6_clr_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr |-> !wdog_rst_n);

  a_r6_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_clr |=> !cfg_clr);

  a_r5_flag_on_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_rst_n) |-> diag_flag);

  a_r9_flash_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    flash_mode |=> wdog_rst_n);

  a_r7_sleep_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ls_off |-> wdog_rst_n);

  a_r11_fall_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdog_rst_n) |-> ($past(tick) || $past(trig)));

  a_r4_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdog_rst_n) |-> ($past(tick) || $past(flash_mode)));

endmodule

bind wdog_window wdog_window_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
  .flash_mode(flash_mode), .wdog_rst_n(wdog_rst_n),
  .diag_flag(diag_flag), .cfg_clr(cfg_clr), .ls_off(ls_off)
);

// File: tb/test_wdog_window.sv
module test_wdog_window;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, trig = 1'b0, auto_dis_en = 1'b0, low_cur = 1'b0;
  logic flash_mode = 1'b0, diag_clr = 1'b0;
  logic wdog_rst_n, diag_flag, cfg_clr, ls_off;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  wdog_window i_wdog_window (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig(trig),
    .auto_dis_en(auto_dis_en), .low_cur(low_cur), .flash_mode(flash_mode),
    .diag_clr(diag_clr), .wdog_rst_n(wdog_rst_n), .diag_flag(diag_flag),
    .cfg_clr(cfg_clr), .ls_off(ls_off)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1'b1;
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; tick = 0; trig = 0; auto_dis_en = 0; low_cur = 0;
    flash_mode = 0; diag_clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset_and_long();
    do_reset();
    chk("R1", "rst_n after reset", wdog_rst_n, 1'b1);
    chk("R1", "diag after reset", diag_flag, 1'b0);
    chk("R1", "cfg_clr after reset", cfg_clr, 1'b0);
    ticks(255);
    chk("R1", "long window tick 255", wdog_rst_n, 1'b1);
    ticks(1);
    chk("R1", "long window expiry", wdog_rst_n, 1'b0);
    chk("R6", "cfg_clr pulse", cfg_clr, 1'b1);
    chk("R5", "diag set", diag_flag, 1'b1);
    @(negedge clk);
    chk("R6", "cfg_clr one cycle", cfg_clr, 1'b0);
    ticks(3);
    chk("R4", "reset after 3 ticks", wdog_rst_n, 1'b0);
    ticks(1);
    chk("R4", "reset released after 4", wdog_rst_n, 1'b1);
    chk("R5", "diag sticky", diag_flag, 1'b1);
    ticks(255);
    chk("R4", "new long window 255", wdog_rst_n, 1'b1);
    @(negedge clk) diag_clr = 1'b1;
    @(negedge clk) diag_clr = 1'b0;
    chk("R5", "diag cleared", diag_flag, 1'b0);
  endtask

  task automatic t_service_loop();
    do_reset();
    pulse_trig();
    for (int k = 0; k < 4; k++) begin
      ticks(12 + k * 6);
      chk("R3", "open offset before trig", wdog_rst_n, 1'b1);
      pulse_trig();
      chk("R3", "valid service", wdog_rst_n, 1'b1);
    end
    ticks(12 + 19);
    pulse_trig();
    chk("R3", "trig at open tick 19", wdog_rst_n, 1'b1);
    ticks(31);
    chk("R3", "open last tick pending", wdog_rst_n, 1'b1);
    ticks(1);
    chk("R3", "too late", wdog_rst_n, 1'b0);
  endtask

  task automatic t_too_early();
    do_reset();
    pulse_trig();
    ticks(11);
    pulse_trig();
    chk("R2", "trig on closed last tick", wdog_rst_n, 1'b0);
    chk("R5", "diag on early", diag_flag, 1'b1);
    do_reset();
    pulse_trig();
    ticks(3);
    pulse_trig();
    chk("R2", "trig mid closed", wdog_rst_n, 1'b0);
  endtask

  task automatic t_edge_only();
    do_reset();
    @(negedge clk) trig = 1'b1;
    ticks(12);
    chk("R10", "held high in closed", wdog_rst_n, 1'b1);
    ticks(19);
    chk("R10", "held high open 19", wdog_rst_n, 1'b1);
    ticks(1);
    chk("R10", "held level not a service", wdog_rst_n, 1'b0);
    @(negedge clk) trig = 1'b0;
  endtask

  task automatic t_tick_only();
    do_reset();
    pulse_trig();
    repeat (400) @(negedge clk);
    chk("R11", "no ticks no reset", wdog_rst_n, 1'b1);
    ticks(31);
    chk("R11", "31 ticks", wdog_rst_n, 1'b1);
    ticks(1);
    chk("R11", "32nd tick expires", wdog_rst_n, 1'b0);
  endtask

  task automatic t_sleep_wake();
    do_reset();
    @(negedge clk) begin auto_dis_en = 1'b1; low_cur = 1'b1; end
    @(negedge clk);
    chk("R7", "ls_off in sleep", ls_off, 1'b1);
    ticks(300);
    chk("R7", "no reset asleep", wdog_rst_n, 1'b1);
    @(negedge clk) low_cur = 1'b0;
    @(negedge clk);
    chk("R8", "ls_off after wake", ls_off, 1'b0);
    ticks(31);
    pulse_trig();
    ticks(5);
    chk("R8", "wake trig at 31 valid", wdog_rst_n, 1'b1);
    @(negedge clk) low_cur = 1'b1;
    @(negedge clk) low_cur = 1'b0;
    @(negedge clk);
    ticks(31);
    chk("R8", "wake 31 ticks", wdog_rst_n, 1'b1);
    ticks(1);
    chk("R8", "wake 32 expires", wdog_rst_n, 1'b0);
    do_reset();
    @(negedge clk) low_cur = 1'b1;
    @(negedge clk);
    chk("R7", "no sleep without enable", ls_off, 1'b0);
    ticks(256);
    chk("R7", "expiry without enable", wdog_rst_n, 1'b0);
  endtask

  task automatic t_flash();
    do_reset();
    @(negedge clk) flash_mode = 1'b1;
    ticks(300);
    chk("R9", "flash no reset", wdog_rst_n, 1'b1);
    pulse_trig();
    ticks(5);
    pulse_trig();
    chk("R9", "flash ignores triggers", wdog_rst_n, 1'b1);
    @(negedge clk) flash_mode = 1'b0;
    ticks(255);
    chk("R9", "long after flash 255", wdog_rst_n, 1'b1);
    ticks(1);
    chk("R9", "long after flash expiry", wdog_rst_n, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset_and_long();
        t_service_loop();
        t_too_early();
        t_edge_only();
        t_tick_only();
        t_sleep_wake();
        t_flash();
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule